// File: doc/BRIEF.md
# CAN Mailbox Interrupt Status Aggregator

This block holds the per-mailbox status bits of a CAN controller with a parameterized number of mailboxes (32 by default). It condenses them into two summary interrupt flags. The first is an overrun/overwrite flag for received messages. The second is a mailbox-empty flag for finished transmit or abort requests. The receive path, transmit engine and abort logic report events as single-cycle strobes that carry a mailbox index. A CPU register port can clear status bits with write-one-to-clear and can queue transmissions.

When a frame arrives for a mailbox that still holds an unread message, the block records the collision. A per-mailbox selection then decides the frame's fate: it is dropped, or it replaces the stored message. The block tells the message storage which one through a store strobe. The two summary flags are not latches. Each is a live OR of its underlying bits, masked by a per-mailbox mask, so a flag drops by itself once those bits are cleared or masked. The interrupt output is a registered OR of the two flags.

Top module: `can_mbx_irq_agg`

## Requirements
- R1: A frame strobe (`rx_valid`) for a mailbox whose data-pending bit (register 0) and remote-pending bit (register 1) are both 0 asserts `rx_store` in the same cycle. In the next cycle it sets the data-pending bit when `rx_remote`=0, or the remote-pending bit when `rx_remote`=1.
- R2: A frame strobe for a mailbox with either pending bit at 1 sets that mailbox's unread bit (register 2) in the next cycle.
- R3: For such a frame, `ovw_sel`=1 for that mailbox asserts `rx_store` and sets the pending bit of the arriving frame type. `ovw_sel`=0 drops the frame: `rx_store`=0 and both pending bits stay as they are.
- R4: `ovr_flag` is 1 exactly when some mailbox has its unread bit at 1 and its `mbx_mask` bit at 0. It changes in the same cycle as the mask.
- R5: A transmit-complete strobe sets the mailbox's transmit-ack bit (register 4) and clears its transmit-pending bit (register 3) in the next cycle.
- R6: An abort-complete strobe sets the mailbox's abort-ack bit (register 5) and clears its transmit-pending bit in the next cycle.
- R7: `empty_flag` is 1 exactly when some mailbox has its transmit-ack or abort-ack bit at 1 and its mask bit at 0.
- R8: Register 6 reads `ovr_flag` at bit 0 and `empty_flag` at bit 1, with all other bits 0. Writes to register 6 change nothing.
- R9: After reset, all status registers, both flags and `irq` are 0.
- R10: Writing 1 to a bit of register 0, 1, 2, 4 or 5 clears that bit, and writing 0 leaves it unchanged. Writing 1 to a bit of register 3 sets it. Register 7 reads 0.
- R11: A hardware set beats a CPU clear of the same bit in the same cycle. A CPU set of a transmit-pending bit beats a completion clear in the same cycle.
- R12: `irq` equals `ovr_flag | empty_flag` as it was one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Frame accepted for a mailbox |
| rx_idx | input | IDX_W | Mailbox of the arriving frame |
| rx_remote | input | 1 | Arriving frame is a remote frame |
| tx_done_valid | input | 1 | Transmission finished |
| tx_done_idx | input | IDX_W | Mailbox whose transmission finished |
| abort_done_valid | input | 1 | Transmit abort finished |
| abort_done_idx | input | IDX_W | Mailbox whose abort finished |
| mbx_mask | input | NUM_MBX | Per-mailbox interrupt mask, 1 = masked |
| ovw_sel | input | NUM_MBX | Per-mailbox collision policy, 1 = overwrite, 0 = drop |
| wr_en | input | 1 | CPU register write |
| wr_addr | input | 3 | Register select for writes |
| wr_data | input | NUM_MBX | Write data, one bit per mailbox |
| rd_addr | input | 3 | Register select for reads |
| rd_data | output | NUM_MBX | Read data (combinational) |
| rx_store | output | 1 | Arriving frame is written into storage |
| ovr_flag | output | 1 | Overrun/overwrite summary flag |
| empty_flag | output | 1 | Mailbox-empty summary flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a frame arriving for a mailbox that already holds an unread message, in the same cycle as a CPU write that clears that mailbox's pending or unread bit. Here the policy choice and the set-beats-clear rule interact. Random stimulus concentrates mailbox indices and write data on a few mailboxes so that these collisions happen often. Directed sequences also build the case explicitly under both policies. Masks that cover exactly the set unread bits are applied directly, so the flags are shown to drop while the bits stay set.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] REG_RXP  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_RFP  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_UMR  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_TXP  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_TXA  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_ABA  = 3'd5;
    localparam logic [ADDR_W-1:0] REG_SUM  = 3'd6;
    localparam int SUM_OVR_BIT   = 0;
    localparam int SUM_EMPTY_BIT = 1;
endpackage

// File: rtl/can_mbx_evt_dec.sv
module can_mbx_evt_dec
    import can_mbx_pkg::*;
#(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX)
) (
    input  logic               rx_valid,
    input  logic [IDX_W-1:0]   rx_idx,
    input  logic               tx_done_valid,
    input  logic [IDX_W-1:0]   tx_done_idx,
    input  logic               abort_done_valid,
    input  logic [IDX_W-1:0]   abort_done_idx,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_MBX-1:0] wr_data,
    output logic [NUM_MBX-1:0] rx_hit,
    output logic [NUM_MBX-1:0] tx_hit,
    output logic [NUM_MBX-1:0] ab_hit,
    output logic [NUM_MBX-1:0] clr_rxp,
    output logic [NUM_MBX-1:0] clr_rfp,
    output logic [NUM_MBX-1:0] clr_umr,
    output logic [NUM_MBX-1:0] set_txp,
    output logic [NUM_MBX-1:0] clr_txa,
    output logic [NUM_MBX-1:0] clr_aba
);
    genvar g;
    generate
        for (g = 0; g < NUM_MBX; g++) begin : g_mbx
            assign rx_hit[g] = rx_valid         && (rx_idx         == IDX_W'(g));
            assign tx_hit[g] = tx_done_valid    && (tx_done_idx    == IDX_W'(g));
            assign ab_hit[g] = abort_done_valid && (abort_done_idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        clr_rxp = '0;
        clr_rfp = '0;
        clr_umr = '0;
        set_txp = '0;
        clr_txa = '0;
        clr_aba = '0;
        if (wr_en) begin
            unique case (wr_addr)
                REG_RXP: clr_rxp = wr_data;
                REG_RFP: clr_rfp = wr_data;
                REG_UMR: clr_umr = wr_data;
                REG_TXP: set_txp = wr_data;
                REG_TXA: clr_txa = wr_data;
                REG_ABA: clr_aba = wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/can_mbx_bank.sv
module can_mbx_bank #(
    parameter int NUM_MBX = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MBX-1:0] rx_hit,
    input  logic               rx_remote,
    input  logic [NUM_MBX-1:0] ovw_sel,
    input  logic [NUM_MBX-1:0] tx_hit,
    input  logic [NUM_MBX-1:0] ab_hit,
    input  logic [NUM_MBX-1:0] clr_rxp,
    input  logic [NUM_MBX-1:0] clr_rfp,
    input  logic [NUM_MBX-1:0] clr_umr,
    input  logic [NUM_MBX-1:0] set_txp,
    input  logic [NUM_MBX-1:0] clr_txa,
    input  logic [NUM_MBX-1:0] clr_aba,
    output logic [NUM_MBX-1:0] rxp,
    output logic [NUM_MBX-1:0] rfp,
    output logic [NUM_MBX-1:0] umr,
    output logic [NUM_MBX-1:0] txp,
    output logic [NUM_MBX-1:0] txa,
    output logic [NUM_MBX-1:0] aba,
    output logic               rx_store
);
    typedef struct packed {
        logic [NUM_MBX-1:0] rxp;
        logic [NUM_MBX-1:0] rfp;
        logic [NUM_MBX-1:0] umr;
        logic [NUM_MBX-1:0] txp;
        logic [NUM_MBX-1:0] txa;
        logic [NUM_MBX-1:0] aba;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_MBX-1:0] pend_v, hit_new, hit_old, store_v, kind_rem;

    always_comb begin
        kind_rem = {NUM_MBX{rx_remote}};
        pend_v   = st_q.rxp | st_q.rfp;
        hit_new  = rx_hit & ~pend_v;
        hit_old  = rx_hit &  pend_v;
        store_v  = hit_new | (hit_old & ovw_sel);

        st_d     = st_q;
        st_d.rxp = (st_q.rxp & ~clr_rxp) | (store_v & ~kind_rem);
        st_d.rfp = (st_q.rfp & ~clr_rfp) | (store_v &  kind_rem);
        st_d.umr = (st_q.umr & ~clr_umr) | hit_old;
        st_d.txp = (st_q.txp & ~(tx_hit | ab_hit)) | set_txp;
        st_d.txa = (st_q.txa & ~clr_txa) | tx_hit;
        st_d.aba = (st_q.aba & ~clr_aba) | ab_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rxp      = st_q.rxp;
    assign rfp      = st_q.rfp;
    assign umr      = st_q.umr;
    assign txp      = st_q.txp;
    assign txa      = st_q.txa;
    assign aba      = st_q.aba;
    assign rx_store = |store_v;
endmodule

// File: rtl/can_mbx_summary.sv
module can_mbx_summary #(
    parameter int NUM_MBX = 32
) (
    input  logic [NUM_MBX-1:0] umr,
    input  logic [NUM_MBX-1:0] txa,
    input  logic [NUM_MBX-1:0] aba,
    input  logic [NUM_MBX-1:0] mbx_mask,
    output logic               ovr_flag,
    output logic               empty_flag
);
    logic [NUM_MBX-1:0] ovr_src, empty_src;

    genvar g;
    generate
        for (g = 0; g < NUM_MBX; g++) begin : g_src
            assign ovr_src[g]   = umr[g] & ~mbx_mask[g];
            assign empty_src[g] = (txa[g] | aba[g]) & ~mbx_mask[g];
        end
    endgenerate

    assign ovr_flag   = |ovr_src;
    assign empty_flag = |empty_src;
endmodule

// File: rtl/can_mbx_irq_agg.sv
module can_mbx_irq_agg
    import can_mbx_pkg::*;
#(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [IDX_W-1:0]   rx_idx,
    input  logic               rx_remote,
    input  logic               tx_done_valid,
    input  logic [IDX_W-1:0]   tx_done_idx,
    input  logic               abort_done_valid,
    input  logic [IDX_W-1:0]   abort_done_idx,
    input  logic [NUM_MBX-1:0] mbx_mask,
    input  logic [NUM_MBX-1:0] ovw_sel,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [NUM_MBX-1:0] wr_data,
    input  logic [2:0]         rd_addr,
    output logic [NUM_MBX-1:0] rd_data,
    output logic               rx_store,
    output logic               ovr_flag,
    output logic               empty_flag,
    output logic               irq
);
    logic [NUM_MBX-1:0] rx_hit, tx_hit, ab_hit;
    logic [NUM_MBX-1:0] clr_rxp, clr_rfp, clr_umr, set_txp, clr_txa, clr_aba;
    logic [NUM_MBX-1:0] rxp_v, rfp_v, umr_v, txp_v, txa_v, aba_v;
    logic               irq_d, irq_q;

    can_mbx_evt_dec #(.NUM_MBX(NUM_MBX)) dec_i (
        .rx_valid(rx_valid), .rx_idx(rx_idx),
        .tx_done_valid(tx_done_valid), .tx_done_idx(tx_done_idx),
        .abort_done_valid(abort_done_valid), .abort_done_idx(abort_done_idx),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rx_hit(rx_hit), .tx_hit(tx_hit), .ab_hit(ab_hit),
        .clr_rxp(clr_rxp), .clr_rfp(clr_rfp), .clr_umr(clr_umr),
        .set_txp(set_txp), .clr_txa(clr_txa), .clr_aba(clr_aba)
    );

    can_mbx_bank #(.NUM_MBX(NUM_MBX)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .rx_hit(rx_hit), .rx_remote(rx_remote), .ovw_sel(ovw_sel),
        .tx_hit(tx_hit), .ab_hit(ab_hit),
        .clr_rxp(clr_rxp), .clr_rfp(clr_rfp), .clr_umr(clr_umr),
        .set_txp(set_txp), .clr_txa(clr_txa), .clr_aba(clr_aba),
        .rxp(rxp_v), .rfp(rfp_v), .umr(umr_v),
        .txp(txp_v), .txa(txa_v), .aba(aba_v),
        .rx_store(rx_store)
    );

    can_mbx_summary #(.NUM_MBX(NUM_MBX)) sum_i (
        .umr(umr_v), .txa(txa_v), .aba(aba_v), .mbx_mask(mbx_mask),
        .ovr_flag(ovr_flag), .empty_flag(empty_flag)
    );

    always_comb begin
        irq_d = ovr_flag | empty_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_RXP: rd_data = rxp_v;
            REG_RFP: rd_data = rfp_v;
            REG_UMR: rd_data = umr_v;
            REG_TXP: rd_data = txp_v;
            REG_TXA: rd_data = txa_v;
            REG_ABA: rd_data = aba_v;
            REG_SUM: begin
                rd_data[SUM_OVR_BIT]   = ovr_flag;
                rd_data[SUM_EMPTY_BIT] = empty_flag;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/can_mbx_irq_agg_chk.sv
module can_mbx_irq_agg_chk #(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_valid,
    input logic [IDX_W-1:0]   rx_idx,
    input logic               tx_done_valid,
    input logic [IDX_W-1:0]   tx_done_idx,
    input logic               abort_done_valid,
    input logic [IDX_W-1:0]   abort_done_idx,
    input logic [NUM_MBX-1:0] mbx_mask,
    input logic [NUM_MBX-1:0] ovw_sel,
    input logic               wr_en,
    input logic [2:0]         wr_addr,
    input logic [NUM_MBX-1:0] wr_data,
    input logic               rx_store,
    input logic               ovr_flag,
    input logic               empty_flag,
    input logic               irq,
    input logic [NUM_MBX-1:0] rxp_v,
    input logic [NUM_MBX-1:0] rfp_v,
    input logic [NUM_MBX-1:0] umr_v,
    input logic [NUM_MBX-1:0] txp_v,
    input logic [NUM_MBX-1:0] txa_v,
    input logic [NUM_MBX-1:0] aba_v
);
    logic rx_pend, txp_set_tx, txp_set_ab;
    assign rx_pend    = rxp_v[rx_idx] | rfp_v[rx_idx];
    assign txp_set_tx = wr_en && (wr_addr == 3'd3) && wr_data[tx_done_idx];
    assign txp_set_ab = wr_en && (wr_addr == 3'd3) && wr_data[abort_done_idx];

    AST_RX_NEW_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_pend) |-> rx_store);  // R1
    AST_RX_OLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_pend) |=> umr_v[$past(rx_idx)]);  // R2
    AST_RX_DROP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_pend && !ovw_sel[rx_idx]) |-> !rx_store);  // R3
    AST_RX_OVW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_pend && ovw_sel[rx_idx]) |-> rx_store);  // R3
    AST_TX_DONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_valid && !txp_set_tx) |=> (txa_v[$past(tx_done_idx)] && !txp_v[$past(tx_done_idx)]));  // R5
    AST_AB_DONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_done_valid && !txp_set_ab) |=> (aba_v[$past(abort_done_idx)] && !txp_v[$past(abort_done_idx)]));  // R6
    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mbx_mask) |-> (!ovr_flag && !empty_flag));  // R7
    AST_UMR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_pend && wr_en && wr_addr == 3'd2 && wr_data[rx_idx]) |=> umr_v[$past(rx_idx)]);  // R11
    AST_IRQ_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(ovr_flag | empty_flag)));  // R12
endmodule

bind can_mbx_irq_agg can_mbx_irq_agg_chk #(.NUM_MBX(NUM_MBX)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_idx(rx_idx),
    .tx_done_valid(tx_done_valid), .tx_done_idx(tx_done_idx),
    .abort_done_valid(abort_done_valid), .abort_done_idx(abort_done_idx),
    .mbx_mask(mbx_mask), .ovw_sel(ovw_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_store(rx_store), .ovr_flag(ovr_flag), .empty_flag(empty_flag), .irq(irq),
    .rxp_v(rxp_v), .rfp_v(rfp_v), .umr_v(umr_v),
    .txp_v(txp_v), .txa_v(txa_v), .aba_v(aba_v)
);

// File: tb/can_mbx_irq_agg_tb_top.sv
`timescale 1ns/1ps
module can_mbx_irq_agg_tb_top;
    localparam int N  = 32;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 0, rx_remote = 0, tx_done_valid = 0, abort_done_valid = 0, wr_en = 0;
    logic [IW-1:0] rx_idx = '0, tx_done_idx = '0, abort_done_idx = '0;
    logic [N-1:0]  mbx_mask = '0, ovw_sel = '0, wr_data = '0;
    logic [2:0]    wr_addr = '0, rd_addr = '0;
    logic [N-1:0]  rd_data;
    logic          rx_store, ovr_flag, empty_flag, irq;

    always #10 clk = ~clk;

    can_mbx_irq_agg #(.NUM_MBX(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_idx(rx_idx), .rx_remote(rx_remote),
        .tx_done_valid(tx_done_valid), .tx_done_idx(tx_done_idx),
        .abort_done_valid(abort_done_valid), .abort_done_idx(abort_done_idx),
        .mbx_mask(mbx_mask), .ovw_sel(ovw_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_store(rx_store), .ovr_flag(ovr_flag), .empty_flag(empty_flag), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    logic [N-1:0] m_rxp = '0, m_rfp = '0, m_umr = '0, m_txp = '0, m_txa = '0, m_aba = '0;
    logic         m_irq = 1'b0;

    function automatic logic f_ovr();
        return |(m_umr & ~mbx_mask);
    endfunction
    function automatic logic f_empty();
        return |((m_txa | m_aba) & ~mbx_mask);
    endfunction
    function automatic logic [N-1:0] f_reg(input int a);
        logic [N-1:0] v;
        v = '0;
        case (a)
            0: v = m_rxp;
            1: v = m_rfp;
            2: v = m_umr;
            3: v = m_txp;
            4: v = m_txa;
            5: v = m_aba;
            6: begin v[0] = f_ovr(); v[1] = f_empty(); end
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Called just after a falling edge: read every register and check the flags.
    task automatic check_all(input string tag_over);
        string deft [0:7];
        deft = '{"R1", "R1", "R2", "R5", "R5", "R6", "R8", "R10"};
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.5;
            chk(tag_over != "" ? tag_over : deft[a], $sformatf("reg%0d", a), rd_data, f_reg(a));
        end
        chk(tag_over != "" ? tag_over : "R4", "ovr_flag", N'(ovr_flag), N'(f_ovr()));
        chk(tag_over != "" ? tag_over : "R7", "empty_flag", N'(empty_flag), N'(f_empty()));
        chk(tag_over != "" ? tag_over : "R12", "irq", N'(irq), N'(m_irq));
    endtask

    // Drive one cycle of inputs, check rx_store, update the model, then check after the edge.
    task automatic apply(input logic rv, input int ri, input logic rem,
                         input logic tv, input int ti, input logic av, input int ai,
                         input logic we, input int wa, input logic [N-1:0] wd, input string tag);
        logic pend, exp_store;
        logic [N-1:0] n_rxp, n_rfp, n_umr, n_txp, n_txa, n_aba;
        rx_valid = rv; rx_idx = IW'(ri); rx_remote = rem;
        tx_done_valid = tv; tx_done_idx = IW'(ti);
        abort_done_valid = av; abort_done_idx = IW'(ai);
        wr_en = we; wr_addr = 3'(wa); wr_data = wd;
        #1;
        pend = m_rxp[ri] | m_rfp[ri];
        exp_store = rv && (!pend || ovw_sel[ri]);
        chk(tag != "" ? tag : "R3", "rx_store", N'(rx_store), N'(exp_store));
        n_rxp = m_rxp; n_rfp = m_rfp; n_umr = m_umr; n_txp = m_txp; n_txa = m_txa; n_aba = m_aba;
        if (we) begin
            case (wa)
                0: n_rxp = n_rxp & ~wd;
                1: n_rfp = n_rfp & ~wd;
                2: n_umr = n_umr & ~wd;
                4: n_txa = n_txa & ~wd;
                5: n_aba = n_aba & ~wd;
                default: ;
            endcase
        end
        if (tv) begin n_txa[ti] = 1'b1; n_txp[ti] = 1'b0; end
        if (av) begin n_aba[ai] = 1'b1; n_txp[ai] = 1'b0; end
        if (we && wa == 3) n_txp = n_txp | wd;
        if (rv) begin
            if (pend) n_umr[ri] = 1'b1;
            if (exp_store) begin
                if (rem) n_rfp[ri] = 1'b1;
                else     n_rxp[ri] = 1'b1;
            end
        end
        m_irq = f_ovr() | f_empty();
        m_rxp = n_rxp; m_rfp = n_rfp; m_umr = n_umr; m_txp = n_txp; m_txa = n_txa; m_aba = n_aba;
        @(negedge clk);
        rx_valid = 0; tx_done_valid = 0; abort_done_valid = 0; wr_en = 0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, '0, tag);
    endtask

    function automatic int pick_idx();
        if ($urandom_range(0, 3) != 0) return int'($urandom_range(0, 3));
        return int'($urandom_range(0, N - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R9");   // R9: reset state

        // R1: new data frame and new remote frame
        apply(1, 2, 0, 0, 0, 0, 0, 0, 0, '0, "R1");
        apply(1, 5, 1, 0, 0, 0, 0, 0, 0, '0, "R1");
        idle("R12");
        // R2/R3: collision with drop policy, then overwrite policy
        ovw_sel = '0;
        apply(1, 2, 1, 0, 0, 0, 0, 0, 0, '0, "R3");
        ovw_sel[5] = 1'b1;
        apply(1, 5, 0, 0, 0, 0, 0, 0, 0, '0, "R2");
        idle("R12");
        // R4: mask exactly the unread mailboxes; flag drops while bits remain
        mbx_mask = N'(1) << 2 | N'(1) << 5;
        #1; check_all("R4");
        mbx_mask = '0;
        #1; check_all("R4");
        // R8: writes to the summary register have no effect
        apply(0, 0, 0, 0, 0, 0, 0, 1, 6, '1, "R8");
        // R10: W1C with zero bits leaves state; one bit clears
        apply(0, 0, 0, 0, 0, 0, 0, 1, 2, '0, "R10");
        apply(0, 0, 0, 0, 0, 0, 0, 1, 2, N'(1) << 2, "R10");
        apply(0, 0, 0, 0, 0, 0, 0, 1, 3, 32'h0000_00f0, "R10");
        // R5/R6: completion and abort
        apply(0, 0, 0, 1, 4, 1, 6, 0, 0, '0, "R5");
        idle("R6");
        // R11: hardware set against CPU clear on the unread bit of mailbox 5 (pending)
        apply(1, 5, 0, 0, 0, 0, 0, 1, 2, N'(1) << 5, "R11");
        // R11: CPU set of transmit pending against completion on mailbox 7
        apply(0, 0, 0, 1, 7, 0, 0, 1, 3, N'(1) << 7, "R11");
        // R11: ack clear vs new completion on mailbox 4
        apply(0, 0, 0, 1, 4, 0, 0, 1, 4, N'(1) << 4, "R11");
        // R7: clear all acks, empty flag drops
        apply(0, 0, 0, 0, 0, 0, 0, 1, 4, '1, "R7");
        apply(0, 0, 0, 0, 0, 0, 0, 1, 5, '1, "R7");
        idle("R12");

        for (int c = 0; c < 4000; c++) begin
            logic we;
            int wa;
            logic [N-1:0] wd;
            if ($urandom_range(0, 40) == 0) mbx_mask = ($urandom_range(0, 1) != 0) ? N'($urandom()) : '0;
            if ($urandom_range(0, 30) == 0) ovw_sel = N'($urandom());
            we = ($urandom_range(0, 3) == 0);
            wa = int'($urandom_range(0, 7));
            wd = ($urandom_range(0, 1) != 0) ? (N'(1) << pick_idx()) : N'($urandom());
            apply($urandom_range(0, 2) == 0, pick_idx(), $urandom_range(0, 1) != 0,
                  $urandom_range(0, 4) == 0, pick_idx(),
                  $urandom_range(0, 6) == 0, pick_idx(),
                  we, wa, wd, "");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule